// File: doc/BRIEF.md
# Eight-Line Priority Encoder with Enable

This block watches eight service request lines and reports, as a 3-bit binary code, the index of the highest-numbered line that is active. A higher index always beats a lower one. A separate request indicator goes high whenever the encoder is enabled and at least one line is asking for service. Without it, a lone request on line 0 and the complete absence of requests would both give code 000. With it, the two cases are easy to tell apart.

An enable input controls the whole encoder. While it is low, both the code and the indicator stay at zero, whatever the request lines do. The block is purely combinational. There are no registers anywhere between the inputs and the outputs. The line count is a parameter, and the code width is derived from it.

Top module: `prienc_top`

## Requirements
- R1: With enable high and exactly one request line active, codeOut equals that line's index, given as an unsigned binary number.
- R2: With enable high and several lines active, codeOut equals the largest active index. Lower-numbered lines have no effect on it.
- R3: reqIndicator is 1 exactly when enable is 1 and at least one request line is 1.
- R4: With enable low, codeOut is 000 and reqIndicator is 0 for every request pattern.
- R5: With enable high and only line 0 active, codeOut is 000 and reqIndicator is 1.
- R6: With enable high and no line active, codeOut is 000 and reqIndicator is 0.
- R7: The code bits carry weights 4, 2 and 1 (codeOut[2], codeOut[1], codeOut[0]). With enable high, codeOut[2] is 1 exactly when any of lines 4 to 7 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enable | input | 1 | Gates the whole encoder; when low, all outputs are zero |
| reqLines | input | 8 | Service request lines; bit i is line i, and higher bits win |
| codeOut | output | 3 | Binary index of the winning request line |
| reqIndicator | output | 1 | High when enabled and any line is requesting |

## Verification
Two things can land in the same evaluation: priority selection among several simultaneous requests, and gating by enable. The same applies to the zero code from line 0, which looks identical to the no-request case unless the indicator is also checked. The bench sweeps all 512 combinations of enable and the request lines. It then adds seeded random patterns that hold many simultaneous requests, with enable toggling freely. Each pattern is judged against a reference model that scans from the top line downward, and the code and the indicator are checked separately so that each masking effect is exposed.

// File: rtl/prienc_pkg.sv
package prienc_pkg;

  // Strobes passed from the control slice to the datapath slice
  typedef struct packed {
    logic gateOn;    // encoder enabled
    logic anyReq;    // at least one raw request present
    logic validOut;  // enabled and a request present
  } encStrobes_t;

endpackage

// File: rtl/prienc_ctrl.sv
module prienc_ctrl
  import prienc_pkg::*;
#(
  parameter int NUM_REQ = 8
) (
  input  logic               enable,
  input  logic [NUM_REQ-1:0] reqLines,
  output encStrobes_t        strobes
);

  always_comb begin
    strobes.gateOn   = enable;
    strobes.anyReq   = |reqLines;
    strobes.validOut = enable & (|reqLines);
  end

endmodule

// File: rtl/prienc_datapath.sv
module prienc_datapath
  import prienc_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int CODE_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] reqLines,
  input  encStrobes_t        strobes,
  output logic [CODE_W-1:0]  codeOut
);

  logic [NUM_REQ-1:0] winLine;
  logic [CODE_W-1:0]  codeRaw;

  // One winner flag per line: active and no higher-numbered line active
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_win
    localparam logic [NUM_REQ-1:0] HIGHER_MASK = {NUM_REQ{1'b1}} << (i + 1);
    assign winLine[i] = reqLines[i] & ~(|(reqLines & HIGHER_MASK));
  end

  always_comb begin
    codeRaw = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (winLine[i]) codeRaw = codeRaw | CODE_W'(i);
    end
    codeOut = strobes.gateOn ? codeRaw : '0;

    // R2
    win_onehot_chk: assert ($onehot0(winLine))
      else $error("more than one winning line");
    // R1
    win_active_chk: assert (!(|winLine) || reqLines[codeRaw])
      else $error("winning code points at an idle line");
    // R2
    no_higher_chk: assert (!(|winLine) || (((reqLines >> codeRaw) >> 1) == '0))
      else $error("a higher line is active than the encoded one");
    // R4
    gate_off_chk: assert (strobes.gateOn || (codeOut == '0))
      else $error("code not zero while disabled");
    // R6
    idle_zero_chk: assert (strobes.anyReq || (codeRaw == '0))
      else $error("nonzero code with no request");
  end

endmodule

// File: rtl/prienc_top.sv
module prienc_top
  import prienc_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int CODE_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               enable,
  input  logic [NUM_REQ-1:0] reqLines,
  output logic [CODE_W-1:0]  codeOut,
  output logic               reqIndicator
);

  encStrobes_t strobes;

  prienc_ctrl #(.NUM_REQ(NUM_REQ)) i_ctrl (
    .enable   (enable),
    .reqLines (reqLines),
    .strobes  (strobes)
  );

  prienc_datapath #(.NUM_REQ(NUM_REQ)) i_dp (
    .reqLines (reqLines),
    .strobes  (strobes),
    .codeOut  (codeOut)
  );

  assign reqIndicator = strobes.validOut;

endmodule

// File: tb/test_prienc_top.sv
module test_prienc_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       enable;
  logic [7:0] reqLines;
  logic [2:0] codeOut;
  logic       reqIndicator;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  prienc_top i_prienc_top (
    .enable       (enable),
    .reqLines     (reqLines),
    .codeOut      (codeOut),
    .reqIndicator (reqIndicator)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] expCode(input logic en, input logic [7:0] p);
    logic [2:0] r = 3'd0;
    if (en) begin
      for (int i = 7; i >= 0; i--) begin
        if (p[i]) begin
          r = 3'(i);
          break;
        end
      end
    end
    return r;
  endfunction

  function automatic logic expInd(input logic en, input logic [7:0] p);
    return en && (p != 8'd0);
  endfunction

  task automatic applyAndCheck(input logic en, input logic [7:0] p);
    string tag;
    logic [2:0] ec;
    logic ei;
    @(negedge clk);
    enable   = en;
    reqLines = p;
    @(posedge clk);
    #1;
    ec = expCode(en, p);
    ei = expInd(en, p);
    if (!en)                 tag = "R4";
    else if (p == 8'h01)     tag = "R5";
    else if (p == 8'h00)     tag = "R6";
    else if ($countones(p) > 1) tag = "R2";
    else                     tag = "R1";
    checks++;
    if (codeOut !== ec) begin
      errors++;
      $display("FAIL %s code en=%0b p=%b actual=%0d expected=%0d", tag, en, p, codeOut, ec);
    end
    checks++;
    if (reqIndicator !== ei) begin
      errors++;
      $display("FAIL R3 indicator en=%0b p=%b actual=%0b expected=%0b", en, p, reqIndicator, ei);
    end
    if (en) begin
      checks++;
      if (codeOut[2] !== (|p[7:4])) begin
        errors++;
        $display("FAIL R7 weight-4 bit p=%b actual=%0b expected=%0b", p, codeOut[2], |p[7:4]);
      end
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    int unsigned seed;
    enable   = 1'b0;
    reqLines = 8'd0;
    // initial state: disabled, idle (R4)
    applyAndCheck(1'b0, 8'h00);
    // R6: enabled, no requests
    applyAndCheck(1'b1, 8'h00);
    // R5: line 0 alone
    applyAndCheck(1'b1, 8'h01);
    // R4: all lines active but disabled
    applyAndCheck(1'b0, 8'hFF);
    // R1: each single line
    for (int i = 0; i < 8; i++) applyAndCheck(1'b1, 8'(1 << i));
    // R2: adjacent pairs and full load
    for (int i = 0; i < 7; i++) applyAndCheck(1'b1, 8'(3 << i));
    applyAndCheck(1'b1, 8'hFF);
    applyAndCheck(1'b1, 8'h81);
    // exhaustive sweep R1 R2 R3 R4 R7
    for (int e = 0; e < 2; e++)
      for (int v = 0; v < 256; v++) applyAndCheck(e[0], 8'(v));
    // seeded random patterns
    seed = 32'd1234;
    void'($urandom(seed));
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] p;
      logic en;
      p  = 8'($urandom());
      en = ($urandom() % 4) != 0;
      applyAndCheck(en, p);
    end
    finishRun();
  end

endmodule